// File: doc/BRIEF.md
# Byte/Word Aliased General Register File

This block holds eight 16-bit general registers for a small datapath. Every access names a register with a 3-bit code and a width bit. With the width bit set, the code picks one of the eight full registers. With it cleared, the code picks a byte. Byte codes only reach the lower and upper halves of registers 0 to 3, so registers 4 to 7 are word-only. Two combinational read ports serve operand fetch.

One operation port carries a command and two operand selectors: a "reg" operand and an "rm" operand, each with its own code and width bit. The port can do three things:
- write external data into the reg operand;
- copy one operand into the other, with a direction bit choosing which operand is the target;
- exchange the two operands in a single clock edge.

A copy or exchange whose two operands differ in width is refused. The block raises a flag for it and leaves every register unchanged.

Top module: `aliased_gpr_file`

## Requirements
- R1: With a width bit of 1, code n (0..7) selects the full 16-bit register n. Command 1 (write) loads op_wdata into the reg operand at the next rising edge.
- R2: With a width bit of 0, codes 0..3 select bits 7:0 of registers 0..3, and codes 4..7 select bits 15:8 of registers 0..3. A byte read returns the byte in bits 7:0 with bits 15:8 zero. A byte write takes op_wdata[7:0].
- R3: A byte write changes only the addressed half. The other half of that register keeps its value.
- R4: Registers 4..7 are reachable only with a width bit of 1. No byte write changes them.
- R5: Command 2 (move) copies one operand into the other. With op_dir = 1 the reg operand receives the rm operand. With op_dir = 0 the rm operand receives the reg operand.
- R6: Command 3 (exchange) swaps the two operands at one rising edge. This includes the two halves of one register.
- R7: An exchange that names the same operand twice leaves that register unchanged.
- R8: When a move or exchange has op_reg_wide different from op_rm_wide, op_illegal is 1 in that same cycle and no register changes. Idle (command 0) and write commands never raise op_illegal.
- R9: A synchronous reset clears all registers at the rising edge. Reset takes priority over a write in the same cycle.
- R10: The two read ports are independent and combinational. A change of read code shows on the data output without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_code | input | 3 | Register code for read port A |
| rd_a_wide | input | 1 | Width bit for read port A (1 word, 0 byte) |
| rd_a_data | output | 16 | Read port A data, bytes zero-extended |
| rd_b_code | input | 3 | Register code for read port B |
| rd_b_wide | input | 1 | Width bit for read port B |
| rd_b_data | output | 16 | Read port B data, bytes zero-extended |
| op_cmd | input | 2 | 0 idle, 1 write, 2 move, 3 exchange |
| op_dir | input | 1 | Move direction: 1 reg operand is target, 0 rm operand is target |
| op_reg_code | input | 3 | Code of the reg operand |
| op_reg_wide | input | 1 | Width bit of the reg operand |
| op_rm_code | input | 3 | Code of the rm operand |
| op_rm_wide | input | 1 | Width bit of the rm operand |
| op_wdata | input | 16 | Data for the write command |
| op_illegal | output | 1 | Mixed-width move or exchange refused |

## Verification
The bench first loads a distinct word into each of the eight registers. This separates word codes that might otherwise alias each other.

It then reads and writes bytes through codes 4..7. This shows whether those codes reach the upper halves of registers 0..3 and not registers 4..7.

Moves run in both directions with unequal operand values, so that a swapped direction bit is visible. Exchanges cover three cases:
- two different words;
- the two halves of one register;
- one operand named twice.

Mixed-width requests and a reset that coincides with a write close the run, and they confirm that nothing is stored in either case.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
   typedef enum logic [1:0] {
      CMD_IDLE  = 2'd0,
      CMD_WRITE = 2'd1,
      CMD_MOVE  = 2'd2,
      CMD_XCHG  = 2'd3
   } gpr_cmd_e;

   localparam int LANES = 2;
endpackage

// File: rtl/gpr_operand_decode.sv
// Turns a register code plus width bit into a register index and a lane mask.
module gpr_operand_decode #(
   parameter int CODE_W = 3
) (
   input  logic [CODE_W-1:0] code,
   input  logic              wide,
   output logic [CODE_W-1:0] idx,
   output logic [1:0]        lanes
);
   initial begin
      if (CODE_W < 2) $error("CODE_W must be at least 2");
   end

   always_comb begin
      if (wide) begin
         idx   = code;
         lanes = 2'b11;
      end else begin
         // upper code bit picks the half, remaining bits pick one of the low registers
         idx   = {1'b0, code[CODE_W-2:0]};
         lanes = code[CODE_W-1] ? 2'b10 : 2'b01;
      end
   end
endmodule

// File: rtl/gpr_read_mux.sv
// Selects a word or one zero-extended half from the register array.
module gpr_read_mux #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter int CODE_W   = 3
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [CODE_W-1:0]               idx,
   input  logic [1:0]                      lanes,
   output logic [DATA_W-1:0]               data
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] word;

   always_comb begin
      word = regs[idx];
      unique case (lanes)
         2'b10:   data = {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]};
         2'b01:   data = {{HALF_W{1'b0}}, word[HALF_W-1:0]};
         default: data = word;
      endcase
   end
endmodule

// File: rtl/gpr_bank.sv
// Register storage with two lane-masked write channels; channel 0 has priority.
module gpr_bank #(
   parameter int DATA_W   = 16,
   parameter int NUM_REGS = 8,
   parameter int IDX_W    = 3
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           wr0_en,
   input  logic [IDX_W-1:0]               wr0_idx,
   input  logic [1:0]                     wr0_lanes,
   input  logic [DATA_W-1:0]              wr0_data,
   input  logic                           wr1_en,
   input  logic [IDX_W-1:0]               wr1_idx,
   input  logic [1:0]                     wr1_lanes,
   input  logic [DATA_W-1:0]              wr1_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
   localparam int HALF_W = DATA_W / 2;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      for (genvar l = 0; l < gpr_pkg::LANES; l++) begin : g_lane
         logic [HALF_W-1:0] lane_q;
         logic hit0, hit1;
         assign hit0 = wr0_en && (wr0_idx == IDX_W'(g)) && wr0_lanes[l];
         assign hit1 = wr1_en && (wr1_idx == IDX_W'(g)) && wr1_lanes[l];
         always_ff @(posedge clk) begin
            if (rst)       lane_q <= '0;
            else if (hit0) lane_q <= wr0_data[l*HALF_W +: HALF_W];
            else if (hit1) lane_q <= wr1_data[l*HALF_W +: HALF_W];
         end
         assign regs_q[g][l*HALF_W +: HALF_W] = lane_q;
      end
   end

   // R3: with no channel active, nothing moves
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!wr0_en && !wr1_en) |=> (regs_q == $past(regs_q)));

   // R3: a low-half-only write leaves the upper half of that register alone
   p_low_write_keeps_high_r3: assert property (@(posedge clk) disable iff (rst)
      (wr0_en && !wr1_en && wr0_lanes == 2'b01)
      |=> (regs_q[$past(wr0_idx)][DATA_W-1:HALF_W] == $past(regs_q[wr0_idx][DATA_W-1:HALF_W])));
endmodule

// File: rtl/aliased_gpr_file.sv
module aliased_gpr_file #(
   parameter int DATA_W = 16,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CODE_W-1:0] rd_a_code,
   input  logic              rd_a_wide,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [CODE_W-1:0] rd_b_code,
   input  logic              rd_b_wide,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic [1:0]        op_cmd,
   input  logic              op_dir,
   input  logic [CODE_W-1:0] op_reg_code,
   input  logic              op_reg_wide,
   input  logic [CODE_W-1:0] op_rm_code,
   input  logic              op_rm_wide,
   input  logic [DATA_W-1:0] op_wdata,
   output logic              op_illegal
);
   import gpr_pkg::*;

   localparam int NUM_REGS = 1 << CODE_W;
   localparam int HALF_W   = DATA_W / 2;
   localparam int N_SEL    = 4;
   localparam int S_A = 0, S_B = 1, S_REG = 2, S_RM = 3;

   if ((DATA_W % 2) != 0 || DATA_W < 4) begin : g_bad_width
      $error("DATA_W must be even and at least 4");
   end

   logic [NUM_REGS-1:0][DATA_W-1:0] regs;
   logic [N_SEL-1:0][CODE_W-1:0]    sel_code;
   logic [N_SEL-1:0]                sel_wide;
   logic [N_SEL-1:0][CODE_W-1:0]    sel_idx;
   logic [N_SEL-1:0][1:0]           sel_lanes;
   logic [N_SEL-1:0][DATA_W-1:0]    sel_data;

   assign sel_code = {op_rm_code, op_reg_code, rd_b_code, rd_a_code};
   assign sel_wide = {op_rm_wide, op_reg_wide, rd_b_wide, rd_a_wide};

   for (genvar p = 0; p < N_SEL; p++) begin : g_sel
      gpr_operand_decode #(.CODE_W(CODE_W)) i_dec (
         .code (sel_code[p]),
         .wide (sel_wide[p]),
         .idx  (sel_idx[p]),
         .lanes(sel_lanes[p])
      );
      gpr_read_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .CODE_W(CODE_W)) i_mux (
         .regs (regs),
         .idx  (sel_idx[p]),
         .lanes(sel_lanes[p]),
         .data (sel_data[p])
      );
   end

   assign rd_a_data = sel_data[S_A];
   assign rd_b_data = sel_data[S_B];

   function automatic logic [DATA_W-1:0] place(input logic [DATA_W-1:0] v, input logic w);
      return w ? v : {2{v[HALF_W-1:0]}};
   endfunction

   gpr_cmd_e cmd;
   logic pair_op;
   assign cmd        = gpr_cmd_e'(op_cmd);
   assign pair_op    = (cmd == CMD_MOVE) || (cmd == CMD_XCHG);
   assign op_illegal = pair_op && (op_reg_wide != op_rm_wide);

   logic              wr0_en, wr1_en;
   logic [CODE_W-1:0] wr0_idx, wr1_idx;
   logic [1:0]        wr0_lanes, wr1_lanes;
   logic [DATA_W-1:0] wr0_data, wr1_data;

   always_comb begin
      wr0_en    = 1'b0;
      wr0_idx   = sel_idx[S_REG];
      wr0_lanes = sel_lanes[S_REG];
      wr0_data  = place(op_wdata, op_reg_wide);
      wr1_en    = 1'b0;
      wr1_idx   = sel_idx[S_RM];
      wr1_lanes = sel_lanes[S_RM];
      wr1_data  = place(sel_data[S_REG], op_rm_wide);
      unique case (cmd)
         CMD_WRITE: wr0_en = 1'b1;
         CMD_MOVE: if (!op_illegal) begin
            wr0_en = 1'b1;
            if (op_dir) begin
               wr0_data = place(sel_data[S_RM], op_reg_wide);
            end else begin
               wr0_idx   = sel_idx[S_RM];
               wr0_lanes = sel_lanes[S_RM];
               wr0_data  = place(sel_data[S_REG], op_rm_wide);
            end
         end
         CMD_XCHG: if (!op_illegal) begin
            wr0_en   = 1'b1;
            wr0_data = place(sel_data[S_RM], op_reg_wide);
            wr1_en   = 1'b1;
         end
         default: ;
      endcase
   end

   gpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .IDX_W(CODE_W)) i_bank (
      .clk      (clk),
      .rst      (rst),
      .wr0_en   (wr0_en),
      .wr0_idx  (wr0_idx),
      .wr0_lanes(wr0_lanes),
      .wr0_data (wr0_data),
      .wr1_en   (wr1_en),
      .wr1_idx  (wr1_idx),
      .wr1_lanes(wr1_lanes),
      .wr1_data (wr1_data),
      .regs_q   (regs)
   );

   // R9: reset empties the whole file at the next edge
   p_reset_clears_r9: assert property (@(posedge clk) rst |=> (regs == '0));

   // R1: word read on port B reflects register n
   p_word_read_map_r1: assert property (@(posedge clk) disable iff (rst)
      rd_b_wide |-> (rd_b_data == regs[rd_b_code]));

   // R2: upper byte codes on port A alias the high half of a low register
   p_high_byte_alias_r2: assert property (@(posedge clk) disable iff (rst)
      (!rd_a_wide && rd_a_code[CODE_W-1])
      |-> (rd_a_data == {{HALF_W{1'b0}}, regs[{1'b0, rd_a_code[CODE_W-2:0]}][DATA_W-1:HALF_W]}));

   // R4: byte writes never reach the word-only registers
   p_byte_write_spares_upper_r4: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_WRITE && !op_reg_wide)
      |=> (regs[NUM_REGS-1:NUM_REGS/2] == $past(regs[NUM_REGS-1:NUM_REGS/2])));

   // R5: move toward the reg operand copies the rm word
   p_move_to_reg_r5: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_MOVE && !op_illegal && op_dir && op_reg_wide)
      |=> (regs[$past(op_reg_code)] == $past(regs[op_rm_code])));

   // R6: word exchange of distinct registers swaps both
   p_xchg_swap_r6: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_XCHG && !op_illegal && op_reg_wide && op_reg_code != op_rm_code)
      |=> (regs[$past(op_reg_code)] == $past(regs[op_rm_code]) &&
           regs[$past(op_rm_code)] == $past(regs[op_reg_code])));

   // R7: exchanging an operand with itself changes nothing
   p_xchg_self_r7: assert property (@(posedge clk) disable iff (rst)
      (cmd == CMD_XCHG && op_reg_wide == op_rm_wide && op_reg_code == op_rm_code)
      |=> (regs == $past(regs)));

   // R8: a refused request leaves the file untouched
   p_illegal_no_change_r8: assert property (@(posedge clk) disable iff (rst)
      op_illegal |=> (regs == $past(regs)));
endmodule

// File: tb/test_aliased_gpr_file.sv
module test_aliased_gpr_file;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  rd_a_code = '0, rd_b_code = '0;
   logic        rd_a_wide = 1'b1, rd_b_wide = 1'b1;
   logic [15:0] rd_a_data, rd_b_data;
   logic [1:0]  op_cmd = '0;
   logic        op_dir = 1'b0;
   logic [2:0]  op_reg_code = '0, op_rm_code = '0;
   logic        op_reg_wide = 1'b1, op_rm_wide = 1'b1;
   logic [15:0] op_wdata = '0;
   logic        op_illegal;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   aliased_gpr_file i_aliased_gpr_file (
      .clk(clk), .rst(rst),
      .rd_a_code(rd_a_code), .rd_a_wide(rd_a_wide), .rd_a_data(rd_a_data),
      .rd_b_code(rd_b_code), .rd_b_wide(rd_b_wide), .rd_b_data(rd_b_data),
      .op_cmd(op_cmd), .op_dir(op_dir),
      .op_reg_code(op_reg_code), .op_reg_wide(op_reg_wide),
      .op_rm_code(op_rm_code), .op_rm_wide(op_rm_wide),
      .op_wdata(op_wdata), .op_illegal(op_illegal)
   );

   typedef struct packed {
      logic [1:0]  cmd;
      logic        dir;
      logic [2:0]  rc;
      logic        rw;
      logic [2:0]  mc;
      logic        mw;
      logic [15:0] wd;
      logic [2:0]  kc;
      logic        kw;
      logic [15:0] exp;
      logic        ill;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 24;
   // cmd dir rc rw mc mw wdata  | read code/wide expected | illegal req
   localparam vec_t TBL [NV] = '{
      '{2'd1,1'b0,3'd0,1'b1,3'd0,1'b1,16'h1234, 3'd0,1'b1,16'h1234, 1'b0,4'd1}, // R1
      '{2'd1,1'b0,3'd1,1'b1,3'd0,1'b1,16'h5678, 3'd1,1'b1,16'h5678, 1'b0,4'd1},
      '{2'd1,1'b0,3'd2,1'b1,3'd0,1'b1,16'h9ABC, 3'd2,1'b1,16'h9ABC, 1'b0,4'd1},
      '{2'd1,1'b0,3'd3,1'b1,3'd0,1'b1,16'hDEF0, 3'd3,1'b1,16'hDEF0, 1'b0,4'd1},
      '{2'd1,1'b0,3'd4,1'b1,3'd0,1'b1,16'h1111, 3'd4,1'b1,16'h1111, 1'b0,4'd1},
      '{2'd1,1'b0,3'd5,1'b1,3'd0,1'b1,16'h2222, 3'd5,1'b1,16'h2222, 1'b0,4'd1},
      '{2'd1,1'b0,3'd6,1'b1,3'd0,1'b1,16'h3333, 3'd6,1'b1,16'h3333, 1'b0,4'd1},
      '{2'd1,1'b0,3'd7,1'b1,3'd0,1'b1,16'h4444, 3'd7,1'b1,16'h4444, 1'b0,4'd1},
      '{2'd0,1'b0,3'd0,1'b1,3'd0,1'b1,16'h0000, 3'd4,1'b0,16'h0012, 1'b0,4'd2}, // R2 code 4 = high of reg 0
      '{2'd0,1'b0,3'd0,1'b1,3'd0,1'b1,16'h0000, 3'd3,1'b0,16'h00F0, 1'b0,4'd2}, // R2 code 3 = low of reg 3
      '{2'd1,1'b0,3'd1,1'b0,3'd0,1'b0,16'hFFAB, 3'd1,1'b1,16'h56AB, 1'b0,4'd3}, // R3 low half only
      '{2'd1,1'b0,3'd6,1'b0,3'd0,1'b0,16'h0077, 3'd2,1'b1,16'h77BC, 1'b0,4'd3}, // R3 high half only
      '{2'd0,1'b0,3'd0,1'b1,3'd0,1'b1,16'h0000, 3'd6,1'b1,16'h3333, 1'b0,4'd4}, // R4 reg 6 untouched
      '{2'd2,1'b1,3'd4,1'b1,3'd0,1'b1,16'h0000, 3'd4,1'b1,16'h1234, 1'b0,4'd5}, // R5 dir 1
      '{2'd2,1'b0,3'd5,1'b1,3'd7,1'b1,16'h0000, 3'd7,1'b1,16'h2222, 1'b0,4'd5}, // R5 dir 0
      '{2'd2,1'b1,3'd0,1'b0,3'd7,1'b0,16'h0000, 3'd0,1'b1,16'h12DE, 1'b0,4'd5}, // R5 byte move
      '{2'd3,1'b0,3'd1,1'b1,3'd3,1'b1,16'h0000, 3'd1,1'b1,16'hDEF0, 1'b0,4'd6}, // R6
      '{2'd0,1'b0,3'd0,1'b1,3'd0,1'b1,16'h0000, 3'd3,1'b1,16'h56AB, 1'b0,4'd6}, // R6 other side
      '{2'd3,1'b0,3'd0,1'b0,3'd4,1'b0,16'h0000, 3'd0,1'b1,16'hDE12, 1'b0,4'd6}, // R6 halves of one reg
      '{2'd3,1'b0,3'd6,1'b1,3'd6,1'b1,16'h0000, 3'd6,1'b1,16'h3333, 1'b0,4'd7}, // R7 word
      '{2'd3,1'b0,3'd2,1'b0,3'd2,1'b0,16'h0000, 3'd2,1'b1,16'h77BC, 1'b0,4'd7}, // R7 byte
      '{2'd2,1'b1,3'd0,1'b1,3'd1,1'b0,16'h0000, 3'd0,1'b1,16'hDE12, 1'b1,4'd8}, // R8 mixed move
      '{2'd3,1'b0,3'd1,1'b0,3'd2,1'b1,16'h0000, 3'd2,1'b1,16'h77BC, 1'b1,4'd8}, // R8 mixed exchange
      '{2'd1,1'b0,3'd5,1'b1,3'd0,1'b0,16'hABCD, 3'd5,1'b1,16'hABCD, 1'b0,4'd8}  // R8 write never flagged
   };

   task automatic check(input int req, input logic [15:0] got, input logic [15:0] exp,
                        input string what);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic read_word_a(input logic [2:0] code, input logic wide);
      rd_a_code = code;
      rd_a_wide = wide;
      #1;
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int r = 0; r < 8; r++) begin
         read_word_a(3'(r), 1'b1);
         check(9, rd_a_data, 16'h0000, "reset value");
      end
      check(9, {15'd0, op_illegal}, 16'h0000, "illegal idle");

      // vector table
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         op_cmd      = TBL[v].cmd;
         op_dir      = TBL[v].dir;
         op_reg_code = TBL[v].rc;
         op_reg_wide = TBL[v].rw;
         op_rm_code  = TBL[v].mc;
         op_rm_wide  = TBL[v].mw;
         op_wdata    = TBL[v].wd;
         #1;
         check(int'(TBL[v].req), {15'd0, op_illegal}, {15'd0, TBL[v].ill}, "op_illegal");
         @(posedge clk);
         #1;
         op_cmd = 2'd0;
         read_word_a(TBL[v].kc, TBL[v].kw);
         check(int'(TBL[v].req), rd_a_data, TBL[v].exp, "readback");
      end

      // R10: two ports at once, combinational update
      @(negedge clk);
      rd_a_code = 3'd4; rd_a_wide = 1'b1;
      rd_b_code = 3'd5; rd_b_wide = 1'b0;
      #1;
      check(10, rd_a_data, 16'h1234, "port A word");
      check(10, rd_b_data, 16'h00DE, "port B high byte");
      rd_b_code = 3'd1;
      #1;
      check(10, rd_b_data, 16'h00F0, "port B change without edge");

      // R9: reset wins over a write in the same cycle
      @(negedge clk);
      rst = 1'b1;
      op_cmd = 2'd1; op_reg_code = 3'd0; op_reg_wide = 1'b1; op_wdata = 16'hFFFF;
      @(posedge clk);
      #1;
      rst = 1'b0;
      op_cmd = 2'd0;
      for (int r = 0; r < 8; r++) begin
         read_word_a(3'(r), 1'b1);
         check(9, rd_a_data, 16'h0000, "cleared after reset with write");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule